// File: doc/BRIEF.md
# SPI Command CRC Guard

This block sits between the byte deserializer of a converter's serial port and its register file. For each command frame it runs an 8-bit CRC over the two command bytes and compares the result with the CRC byte the host appends. It then decides whether the decoded command may execute. Leading pad bytes pass through the frame without touching the CRC. A CRC-enable configuration input switches the whole check on or off.

A failed check suppresses the command and raises a sticky error flag. That flag is meant to appear as one bit of the status byte. While the flag is up, register writes are refused, except a write aimed at the status register, which is how software clears the flag. Reads are handled by a narrower rule: a read is refused only when the read frame immediately before it failed its CRC. The decision is registered and appears one cycle after the frame-end strobe. It comes with separate write and read permission outputs.

Top module: `spi_cmd_crc_guard`

## Requirements
- R1: The CRC uses generator 0x07 (x^8+x^2+x+1), is processed MSB first and is preset to 0xFF at each `frame_start`. It runs over the bytes marked as command bytes (`byte_kind` = 1). A frame whose received CRC byte (`byte_kind` = 2) equals this value executes.
- R2: Bytes marked as pad (`byte_kind` = 0) do not change the CRC. A frame with pads in front of correctly protected command bytes executes.
- R3: With `crc_en` = 1, a CRC mismatch suppresses the command (`exec_ok` = 0, no permission) and sets `err_flag`.
- R4: While `err_flag` is 1, a CRC-correct write to any address other than `STATUS_ADDR` (default 0) is refused. A write to `STATUS_ADDR` is allowed.
- R5: An allowed write to `STATUS_ADDR` whose data has bit `ERR_BIT` (default 6) set clears `err_flag`. Such a write with that bit at 0 leaves the flag set.
- R6: A CRC-correct read is refused only if the previous read frame failed its CRC. Otherwise it executes, even while `err_flag` is 1.
- R7: With `crc_en` = 0, every command executes whatever the CRC byte is, and `err_flag` is not set.
- R8: A frame that ends without a CRC byte counts as a mismatch.
- R9: After reset, `err_flag`, the read history and all decision outputs are 0.
- R10: `decision_vld` pulses for one cycle, on the cycle after `frame_end`. `wr_allow` = `exec_ok` for a write (`cmd_type` = 2), and `rd_allow` = `exec_ok` for a read (`cmd_type` = 1). For other commands (`cmd_type` = 0) both permissions are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_en | input | 1 | CRC checking enable |
| frame_start | input | 1 | One-cycle pulse at chip-select assertion |
| byte_vld | input | 1 | Deserialized byte strobe |
| byte_kind | input | 2 | Byte role: 0 pad, 1 command, 2 CRC |
| byte_data | input | 8 | Deserialized byte |
| frame_end | input | 1 | One-cycle pulse at frame end, command fields valid |
| cmd_type | input | 2 | Decoded command: 0 other, 1 read, 2 write |
| cmd_addr | input | ADDR_W | Target register address |
| cmd_wdata | input | 8 | Write data of a write command |
| decision_vld | output | 1 | Decision strobe |
| exec_ok | output | 1 | Command may execute |
| wr_allow | output | 1 | Register write permitted |
| rd_allow | output | 1 | Register read permitted |
| err_flag | output | 1 | Sticky CRC error flag |

## Verification
The assertions assume a well-formed frame. `frame_start` comes first and stands alone. Bytes arrive only between `frame_start` and `frame_end`. `frame_end` is a single pulse with the command fields held stable in that same cycle. The bench's frame task always drives this order: the start pulse, then the pads, command bytes and CRC byte on separate cycles, then the end pulse. It also keeps `crc_en` constant for the length of each frame, so the checks on flag set and clear only ever see frame-level events.

// File: rtl/crc_guard_pkg.sv
package crc_guard_pkg;
  typedef enum logic [1:0] {KIND_PAD = 2'd0, KIND_CMD = 2'd1, KIND_CRC = 2'd2} byte_kind_e;
  typedef enum logic [1:0] {OP_OTHER = 2'd0, OP_READ = 2'd1, OP_WRITE = 2'd2} cmd_op_e;

  // one byte through the CRC register, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] cur, input logic [7:0] din,
                                           input logic [7:0] poly);
    logic [7:0] r;
    r = cur ^ din;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ poly) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/crc8_accum.sv
module crc8_accum import crc_guard_pkg::*; #(
  parameter logic [7:0] POLY = 8'h07,
  parameter logic [7:0] INIT = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       take,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  logic [7:0] base;
  assign base = restart ? INIT : crc;

  always_ff @(posedge clk) begin
    if (rst)       crc <= INIT;
    else if (take) crc <= crc8_step(base, din, POLY);
    else           crc <= base;
  end
endmodule

// File: rtl/frame_tracker.sv
module frame_tracker import crc_guard_pkg::*; #(
  parameter int CMD_BYTES = 2,
  localparam int CW = $clog2(CMD_BYTES + 2)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic       byte_vld,
  input  logic [1:0] byte_kind,
  input  logic [7:0] byte_data,
  input  logic [7:0] calc_crc,
  output logic       cmd_take,
  output logic       crc_match
);
  logic [CW-1:0] cmd_cnt;
  logic          got_crc;
  logic [7:0]    rx_crc;
  logic          is_cmd, is_crc;

  assign is_cmd   = byte_vld && (byte_kind_e'(byte_kind) == KIND_CMD);
  assign is_crc   = byte_vld && (byte_kind_e'(byte_kind) == KIND_CRC);
  // command bytes feed the CRC only before the CRC byte, and only up to the count
  assign cmd_take = is_cmd && !(got_crc && !frame_start)
                    && (frame_start || cmd_cnt < CW'(CMD_BYTES));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_cnt <= '0;
      got_crc <= 1'b0;
      rx_crc  <= '0;
    end else begin
      if (frame_start) begin
        cmd_cnt <= '0;
        got_crc <= 1'b0;
      end
      if (cmd_take) cmd_cnt <= (frame_start ? CW'(0) : cmd_cnt) + CW'(1);
      if (is_cmd && !cmd_take && !got_crc) cmd_cnt <= CW'(CMD_BYTES + 1);
      if (is_crc && (frame_start || !got_crc)) begin
        got_crc <= 1'b1;
        rx_crc  <= byte_data;
      end
    end
  end

  assign crc_match = got_crc && (cmd_cnt == CW'(CMD_BYTES)) && (rx_crc == calc_crc);
endmodule

// File: rtl/spi_cmd_crc_guard.sv
module spi_cmd_crc_guard import crc_guard_pkg::*; #(
  parameter int          ADDR_W      = 4,
  parameter int          STATUS_ADDR = 0,
  parameter int          ERR_BIT     = 6,
  parameter int          CMD_BYTES   = 2,
  parameter logic [7:0]  POLY        = 8'h07,
  parameter logic [7:0]  INIT        = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              crc_en,
  input  logic              frame_start,
  input  logic              byte_vld,
  input  logic [1:0]        byte_kind,
  input  logic [7:0]        byte_data,
  input  logic              frame_end,
  input  logic [1:0]        cmd_type,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  output logic              decision_vld,
  output logic              exec_ok,
  output logic              wr_allow,
  output logic              rd_allow,
  output logic              err_flag
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

  logic [7:0] calc_crc;
  logic       cmd_take, crc_match;
  logic       prev_rd_fail;

  crc8_accum #(.POLY(POLY), .INIT(INIT)) u_crc (
    .clk(clk), .rst(rst), .restart(frame_start), .take(cmd_take),
    .din(byte_data), .crc(calc_crc));

  frame_tracker #(.CMD_BYTES(CMD_BYTES)) u_trk (
    .clk(clk), .rst(rst), .frame_start(frame_start), .byte_vld(byte_vld),
    .byte_kind(byte_kind), .byte_data(byte_data), .calc_crc(calc_crc),
    .cmd_take(cmd_take), .crc_match(crc_match));

  cmd_op_e op;
  logic    crc_good, is_wr, is_rd, go, clr;
  assign op       = cmd_op_e'(cmd_type);
  assign is_wr    = (op == OP_WRITE);
  assign is_rd    = (op == OP_READ);
  assign crc_good = !crc_en || crc_match;

  always_comb begin
    go = crc_good;
    if (is_wr && err_flag && (cmd_addr != STAT_A)) go = 1'b0;
    if (is_rd && prev_rd_fail)                     go = 1'b0;
  end
  assign clr = go && is_wr && (cmd_addr == STAT_A) && cmd_wdata[ERR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      decision_vld <= 1'b0;
      exec_ok      <= 1'b0;
      wr_allow     <= 1'b0;
      rd_allow     <= 1'b0;
      err_flag     <= 1'b0;
      prev_rd_fail <= 1'b0;
    end else begin
      decision_vld <= frame_end;
      exec_ok      <= frame_end && go;
      wr_allow     <= frame_end && go && is_wr;
      rd_allow     <= frame_end && go && is_rd;
      if (frame_end) begin
        if (!crc_good)  err_flag <= 1'b1;
        else if (clr)   err_flag <= 1'b0;
        if (is_rd)      prev_rd_fail <= !crc_good;
      end
    end
  end

  // R3: the flag only rises after a frame end with checking on
  assert_flag_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> $past(frame_end && crc_en));
  // R4: no write to a non-status register while the flag stands
  assert_no_wr_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_end && err_flag && is_wr && cmd_addr != STAT_A) |=> !wr_allow);
  // R5: the flag falls only through a status write carrying the error bit
  assert_clear_path_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(err_flag) && !$past(rst)) |->
      $past(frame_end && is_wr && cmd_addr == STAT_A && cmd_wdata[ERR_BIT]));
  // R7: with checking off, a clear flag stays clear
  assert_off_no_set_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_end && !crc_en && !err_flag) |=> !err_flag);
  // R10: decisions follow a frame end by exactly one cycle
  assert_vld_timing_R10: assert property (@(posedge clk) disable iff (rst)
    decision_vld |-> $past(frame_end));
  assert_perm_excl_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_allow || rd_allow) |-> (exec_ok && !(wr_allow && rd_allow)));
endmodule

// File: tb/test_spi_cmd_crc_guard.sv
module test_spi_cmd_crc_guard;
  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic       rst, crc_en, frame_start, byte_vld, frame_end;
  logic [1:0] byte_kind, cmd_type;
  logic [7:0] byte_data, cmd_wdata;
  logic [3:0] cmd_addr;
  logic       decision_vld, exec_ok, wr_allow, rd_allow, err_flag;

  int checks = 0, fails = 0;

  spi_cmd_crc_guard i_spi_cmd_crc_guard (
    .clk(clk), .rst(rst), .crc_en(crc_en), .frame_start(frame_start),
    .byte_vld(byte_vld), .byte_kind(byte_kind), .byte_data(byte_data),
    .frame_end(frame_end), .cmd_type(cmd_type), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .decision_vld(decision_vld), .exec_ok(exec_ok),
    .wr_allow(wr_allow), .rd_allow(rd_allow), .err_flag(err_flag));

  // bit-serial reference: poly 0x07, MSB first
  function automatic logic [7:0] ref_crc(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] c = 8'hFF;
    logic [15:0] d = {a, b};
    for (int i = 15; i >= 0; i--) begin
      logic fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] k, input logic [7:0] d);
    byte_vld = 1'b1; byte_kind = k; byte_data = d;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  // sends a frame; outputs are sampled at the negedge after the frame-end edge
  task automatic frame(input logic en, input logic [1:0] op, input logic [3:0] a,
                       input logic [7:0] wd, input int pads, input logic bad,
                       input logic with_crc);
    logic [7:0] c0 = {op, a, 2'b01} ^ 8'h5A;
    logic [7:0] c1 = wd;
    crc_en = en;
    frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
    for (int p = 0; p < pads; p++) put(2'd0, 8'h00);
    put(2'd1, c0);
    put(2'd1, c1);
    if (with_crc) put(2'd2, ref_crc(c0, c1) ^ (bad ? 8'h01 : 8'h00));
    frame_end = 1'b1; cmd_type = op; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  typedef struct packed {
    logic       en;
    logic [1:0] op;
    logic [3:0] addr;
    logic [7:0] wd;
    logic       bad;
    logic       x_exec;
    logic       x_flag;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd2, 4'd3, 8'h11, 1'b0, 1'b1, 1'b0, 4'd1},  // R1 good write
    '{1'b1, 2'd1, 4'd3, 8'h00, 1'b0, 1'b1, 1'b0, 4'd1},  // R1 good read
    '{1'b1, 2'd2, 4'd3, 8'h22, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 bad write
    '{1'b1, 2'd2, 4'd3, 8'h33, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 locked write
    '{1'b1, 2'd1, 4'd3, 8'h00, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 read under flag
    '{1'b1, 2'd1, 4'd3, 8'h00, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 bad read
    '{1'b1, 2'd1, 4'd3, 8'h00, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 read after failed read
    '{1'b1, 2'd1, 4'd3, 8'h00, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 recovered
    '{1'b1, 2'd2, 4'd0, 8'h40, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 clear
    '{1'b1, 2'd2, 4'd3, 8'h44, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 unlocked
    '{1'b0, 2'd2, 4'd3, 8'h55, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 off write
    '{1'b0, 2'd1, 4'd3, 8'h00, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 off read
    '{1'b1, 2'd0, 4'd5, 8'h66, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 bad other
    '{1'b1, 2'd2, 4'd0, 8'h00, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 bit clear, flag stays
    '{1'b1, 2'd2, 4'd0, 8'h40, 1'b1, 1'b0, 1'b1, 4'd5},  // R5 bad CRC, no clear
    '{1'b1, 2'd2, 4'd0, 8'h40, 1'b0, 1'b1, 1'b0, 4'd5}   // R5 clear
  };

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; crc_en = 1'b1; frame_start = 0; byte_vld = 0; byte_kind = 0;
    byte_data = 0; frame_end = 0; cmd_type = 0; cmd_addr = 0; cmd_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset flag", err_flag, 0);
    chk("R9 reset vld", {decision_vld, exec_ok, wr_allow, rd_allow}, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      string tag = $sformatf("R%0d vec%0d", v.req, i);
      frame(v.en, v.op, v.addr, v.wd, 0, v.bad, 1'b1);
      chk({tag, " vld"}, decision_vld, 1);
      chk({tag, " exec"}, exec_ok, v.x_exec);
      chk({tag, " flag"}, err_flag, v.x_flag);
      chk({tag, " wr"}, wr_allow, v.x_exec && v.op == 2'd2);   // R10
      chk({tag, " rd"}, rd_allow, v.x_exec && v.op == 2'd1);   // R10
      @(negedge clk);
      chk({tag, " R10 pulse"}, decision_vld, 0);
    end

    // R2: pad bytes in front do not disturb the CRC
    frame(1'b1, 2'd2, 4'd2, 8'h9C, 3, 1'b0, 1'b1);
    chk("R2 pads exec", exec_ok, 1);
    chk("R2 pads flag", err_flag, 0);
    // R8: frame without CRC byte
    frame(1'b1, 2'd1, 4'd2, 8'h00, 0, 1'b0, 1'b0);
    chk("R8 no crc exec", exec_ok, 0);
    chk("R8 no crc flag", err_flag, 1);
    // R6: next read blocked because the previous read frame failed
    frame(1'b1, 2'd1, 4'd2, 8'h00, 0, 1'b0, 1'b1);
    chk("R6 follow-up read", rd_allow, 0);
    // R9: reset clears flag and read history
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    chk("R9 flag after reset", err_flag, 0);
    frame(1'b1, 2'd1, 4'd2, 8'h00, 0, 1'b0, 1'b1);
    chk("R9 read history cleared", rd_allow, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule